// File: doc/BRIEF.md
# Two-Byte Bidirectional Mailbox Channel

This block carries bytes between a host bus and a coprocessor (parasite) bus. It has one path from host to parasite and one from parasite to host. Each path stores up to two bytes and delivers them in the order they were written. Every byte interface uses valid/ready. A writer offers a byte by raising `*_in_valid`, and the byte is taken on a rising clock edge where `*_in_ready` is also high. A reader takes the head byte on a rising edge where both `*_out_valid` and `*_out_ready` are high. While `*_in_ready` is low, the writer may hold its byte as long as it likes. The ready and valid flags on the storage side do not depend on the input strobes in the same cycle.

A seven-bit control register sets the behaviour of the channel. Writing it with bit 7 high sets the masked bits, and writing it with bit 7 low clears them. Three bits act inside the block:
- Bit 4 (pair mode) makes each path transfer bytes in pairs.
- Bit 3 (alert enable) gates a non-maskable interrupt request toward the parasite.
- Bit 6 (flush) empties both paths and then clears itself.

Bits 0, 1, 2 and 5 are stored and reported only. After a hard reset, the parasite-to-host path holds one placeholder byte. This keeps the parasite request quiet until the host drains that byte.

Top module: `duplex_pair_mailbox`

## Requirements
- R1: After a hard reset, the control bits read 0 and the host-to-parasite path is empty (`h2p_out_valid`=0, `h2p_in_ready`=1). The parasite-to-host path holds one byte equal to `PRELOAD_BYTE` (`p2h_out_valid`=1, `p2h_out_data`=`PRELOAD_BYTE`, `p2h_in_ready`=0), and `par_nmi`=0.
- R2: A control write with bit 7 set makes `ctl_bits |= wr[6:0]`. A control write with bit 7 clear makes `ctl_bits &= ~wr[6:0]`. Either takes effect at the next edge.
- R3: With bit 4 clear, a path holds one byte. Its reader valid is high while it holds one or more bytes, and its writer ready is high only while it is empty.
- R4: With bit 4 set, the reader valid rises only after two bytes are stored. It then stays high until both bytes have been read.
- R5: With bit 4 set, the writer ready stays high until the second byte is stored. It then stays low until the path is empty again.
- R6: Each path delivers bytes in the order they were written.
- R7: When `*_out_valid` is low, `*_out_data` shows the last byte read and the flags do not change. An input offer while `*_in_ready` is low is ignored: the path's flags and data stay as they were.
- R8: `par_nmi` = bit 3 AND (`h2p_out_valid` OR room on the parasite-to-host path). With bit 4 clear, room means `p2h_in_ready`. With bit 4 set, room means that path is empty.
- R9: Setting bit 6 makes it read 1 for exactly one cycle. On the next edge both paths return to their R1 state, any transfer offered in that cycle is dropped, bit 6 clears, and the other control bits keep their values.
- R10: A hard reset clears bits 3 and 4, whatever they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Bit 7 selects set or clear; bits 6..0 are the mask |
| ctl_bits | output | 7 | Current control bits |
| h2p_in_valid | input | 1 | Host offers a byte |
| h2p_in_ready | output | 1 | Host-side not-full flag |
| h2p_in_data | input | 8 | Byte from host |
| h2p_out_valid | output | 1 | Parasite-side data-available flag |
| h2p_out_ready | input | 1 | Parasite takes the head byte |
| h2p_out_data | output | 8 | Head byte, or the last byte read |
| p2h_in_valid | input | 1 | Parasite offers a byte |
| p2h_in_ready | output | 1 | Parasite-side not-full flag |
| p2h_in_data | input | 8 | Byte from parasite |
| p2h_out_valid | output | 1 | Host-side data-available flag |
| p2h_out_ready | input | 1 | Host takes the head byte |
| p2h_out_data | output | 8 | Head byte, or the last byte read |
| par_nmi | output | 1 | Interrupt request toward the parasite |

## Verification
The properties assume that no control write arrives in a cycle where an input offer is checked for being ignored. They also assume the mask of a set or clear write is judged on bits 0 to 5 only, because bit 6 clears itself. The stimulus changes every input a fixed delay after the rising edge and holds it through the next edge. Mode changes, flushes and offers against a full path are mixed into a long pseudo-random stretch, so that pair mode is entered and left with partly filled paths.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CTL_W     = 7;
  localparam int CTL_HIRQ  = 0;
  localparam int CTL_PIRQ  = 1;
  localparam int CTL_AUX   = 2;
  localparam int CTL_ALERT = 3;
  localparam int CTL_PAIR  = 4;
  localparam int CTL_SPARE = 5;
  localparam int CTL_FLUSH = 6;
  localparam int WR_SEL    = CTL_W;   // set/clear selector bit of a write
  typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CTL_W:0] wr_data,
  output ctl_t          bits,
  output logic          flush
);
  ctl_t bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (wr_en) begin
      if (wr_data[WR_SEL]) bits_d = bits_q | wr_data[CTL_W-1:0];
      else                 bits_d = bits_q & ~wr_data[CTL_W-1:0];
    end
    // flush lives for one cycle only
    if (bits_q[CTL_FLUSH]) bits_d[CTL_FLUSH] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits  = bits_q;
  assign flush = bits_q[CTL_FLUSH];
endmodule

// File: rtl/mbx_path.sv
module mbx_path #(
  parameter int                 DATA_W      = 8,
  parameter bit                 PRELOAD_EN  = 1'b0,
  parameter logic [DATA_W-1:0]  PRELOAD_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              pair_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              empty
);
  localparam int DEPTH = 2;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = PRELOAD_EN ? CNT_W'(1) : '0;
  localparam logic [PTR_W-1:0] WP_INIT  = PRELOAD_EN ? PTR_W'(1) : '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              pair_full;
  logic [DATA_W-1:0] last_q;
  logic              push, pop;

  // single-byte mode: one byte of capacity; pair mode: fill a pair, then drain it
  assign in_ready  = pair_mode ? (!pair_full && cnt != CNT_FULL) : (cnt == '0);
  assign out_valid = pair_mode ? pair_full : (cnt != '0);
  assign push      = in_valid  && in_ready  && !flush;
  assign pop       = out_valid && out_ready && !flush;
  assign empty     = (cnt == '0);
  assign out_data  = out_valid ? slot[rp] : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_INIT; wp <= WP_INIT; rp <= '0; pair_full <= 1'b0;
    end else if (flush) begin
      cnt <= CNT_INIT; wp <= WP_INIT; rp <= '0; pair_full <= 1'b0;
    end else begin
      if (push) begin
        wp  <= wp + 1'b1;
        cnt <= cnt + 1'b1;
        if (cnt == CNT_ONE) pair_full <= 1'b1;
      end
      if (pop) begin
        rp  <= rp + 1'b1;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_ONE) pair_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_q <= '0;
    else if (pop) last_q <= slot[rp];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam bool_t_dummy = 0;
    localparam logic [DATA_W-1:0] INIT = (PRELOAD_EN && g == 0) ? PRELOAD_VAL : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot[g] <= INIT;
      else if (flush && PRELOAD_EN && g == 0) slot[g] <= PRELOAD_VAL;
      else if (push && wp == PTR_W'(g))      slot[g] <= in_data;
    end
  end
endmodule

// File: rtl/duplex_pair_mailbox.sv
module duplex_pair_mailbox
  import mbx_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] PRELOAD_BYTE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [7:0]        ctl_wr_data,
  output logic [6:0]        ctl_bits,
  input  logic              h2p_in_valid,
  output logic              h2p_in_ready,
  input  logic [DATA_W-1:0] h2p_in_data,
  output logic              h2p_out_valid,
  input  logic              h2p_out_ready,
  output logic [DATA_W-1:0] h2p_out_data,
  input  logic              p2h_in_valid,
  output logic              p2h_in_ready,
  input  logic [DATA_W-1:0] p2h_in_data,
  output logic              p2h_out_valid,
  input  logic              p2h_out_ready,
  output logic [DATA_W-1:0] p2h_out_data,
  output logic              par_nmi
);
  ctl_t bits;
  logic flush, pair_mode, p2h_empty, h2p_empty, p2h_room;

  mbx_ctrl u_ctrl (
    .clk, .rst_n, .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .bits(bits), .flush(flush)
  );

  assign pair_mode = bits[CTL_PAIR];
  assign ctl_bits  = bits;

  mbx_path #(.DATA_W(DATA_W), .PRELOAD_EN(1'b0), .PRELOAD_VAL('0)) u_h2p (
    .clk, .rst_n, .flush, .pair_mode,
    .in_valid(h2p_in_valid), .in_ready(h2p_in_ready), .in_data(h2p_in_data),
    .out_valid(h2p_out_valid), .out_ready(h2p_out_ready), .out_data(h2p_out_data),
    .empty(h2p_empty)
  );

  // placeholder byte keeps the parasite alert quiet after reset and flush
  mbx_path #(.DATA_W(DATA_W), .PRELOAD_EN(1'b1), .PRELOAD_VAL(PRELOAD_BYTE)) u_p2h (
    .clk, .rst_n, .flush, .pair_mode,
    .in_valid(p2h_in_valid), .in_ready(p2h_in_ready), .in_data(p2h_in_data),
    .out_valid(p2h_out_valid), .out_ready(p2h_out_ready), .out_data(p2h_out_data),
    .empty(p2h_empty)
  );

  assign p2h_room = pair_mode ? p2h_empty : p2h_in_ready;
  assign par_nmi  = bits[CTL_ALERT] && (h2p_out_valid || p2h_room);
endmodule

// File: rtl/mailbox_chk.sv
module mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr_en,
  input logic [7:0] ctl_wr_data,
  input logic [6:0] ctl_bits,
  input logic       h2p_in_valid,
  input logic       h2p_in_ready,
  input logic       h2p_out_valid,
  input logic       h2p_out_ready,
  input logic [7:0] h2p_out_data,
  input logic       par_nmi
);
  // R3
  no_both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h2p_in_ready && h2p_out_valid));
  // R2
  set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_data[7]) |=> ((ctl_bits[5:0] & $past(ctl_wr_data[5:0])) == $past(ctl_wr_data[5:0])));
  // R2
  clear_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !ctl_wr_data[7]) |=> ((ctl_bits & $past(ctl_wr_data[6:0])) == 7'd0));
  // R9
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[6] |=> !ctl_bits[6]);
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[6] |=> (h2p_in_ready && !h2p_out_valid));
  // R8
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_nmi |-> ctl_bits[3]);
  // R7
  ignored_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h2p_in_valid && !h2p_in_ready && !h2p_out_ready && !ctl_bits[6] && !ctl_wr_en)
      |=> ($stable(h2p_out_valid) && $stable(h2p_out_data) && $stable(h2p_in_ready)));
endmodule

bind duplex_pair_mailbox mailbox_chk u_chk (
  .clk, .rst_n, .ctl_wr_en, .ctl_wr_data, .ctl_bits,
  .h2p_in_valid, .h2p_in_ready, .h2p_out_valid, .h2p_out_ready,
  .h2p_out_data, .par_nmi
);

// File: tb/duplex_pair_mailbox_test.sv
module duplex_pair_mailbox_test;
  localparam int PERIOD = 10;
  localparam logic [7:0] PRE = 8'h00;

  logic clk = 0, rst_n = 0;
  logic ctl_wr_en = 0; logic [7:0] ctl_wr_data = 0; logic [6:0] ctl_bits;
  logic h2p_in_valid = 0, h2p_in_ready, h2p_out_valid, h2p_out_ready = 0;
  logic [7:0] h2p_in_data = 0, h2p_out_data;
  logic p2h_in_valid = 0, p2h_in_ready, p2h_out_valid, p2h_out_ready = 0;
  logic [7:0] p2h_in_data = 0, p2h_out_data;
  logic par_nmi;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  duplex_pair_mailbox #(.DATA_W(8), .PRELOAD_BYTE(PRE)) uut (.*);

  // ---------------- behavioural reference ----------------
  logic [7:0] mq_h[$], mq_p[$];
  bit  md_h, md_p;
  logic [7:0] ml_h, ml_p;
  logic [6:0] mctl;

  function automatic bit m_ready(int sz, bit dr, bit pm);
    return pm ? (!dr && sz < 2) : (sz == 0);
  endfunction
  function automatic bit m_valid(int sz, bit dr, bit pm);
    return pm ? dr : (sz != 0);
  endfunction

  task automatic m_paths_init();
    mq_h.delete(); mq_p.delete(); mq_p.push_back(PRE);
    md_h = 0; md_p = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_paths_init(); ml_h = 0; ml_p = 0; mctl = 0;
    end else begin
      bit pm; logic [6:0] n;
      pm = mctl[4];
      if (mctl[6]) m_paths_init();
      else begin
        if (h2p_in_valid && m_ready(mq_h.size(), md_h, pm)) begin
          mq_h.push_back(h2p_in_data); if (mq_h.size() == 2) md_h = 1;
        end else if (h2p_out_ready && m_valid(mq_h.size(), md_h, pm)) begin
          ml_h = mq_h.pop_front(); if (mq_h.size() == 0) md_h = 0;
        end
        if (p2h_in_valid && m_ready(mq_p.size(), md_p, pm)) begin
          mq_p.push_back(p2h_in_data); if (mq_p.size() == 2) md_p = 1;
        end else if (p2h_out_ready && m_valid(mq_p.size(), md_p, pm)) begin
          ml_p = mq_p.pop_front(); if (mq_p.size() == 0) md_p = 0;
        end
      end
      n = mctl;
      if (ctl_wr_en) n = ctl_wr_data[7] ? (mctl | ctl_wr_data[6:0]) : (mctl & ~ctl_wr_data[6:0]);
      if (mctl[6]) n[6] = 0;
      mctl = n;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit pm, hv, pv, room;
      pm = mctl[4];
      hv = m_valid(mq_h.size(), md_h, pm);
      pv = m_valid(mq_p.size(), md_p, pm);
      room = pm ? (mq_p.size() == 0) : m_ready(mq_p.size(), md_p, pm);
      chk("R2", "ctl_bits", ctl_bits, mctl);
      chk(pm ? "R4" : "R3", "h2p_out_valid", h2p_out_valid, hv);
      chk(pm ? "R5" : "R3", "h2p_in_ready", h2p_in_ready, m_ready(mq_h.size(), md_h, pm));
      chk(pm ? "R4" : "R3", "p2h_out_valid", p2h_out_valid, pv);
      chk(pm ? "R5" : "R3", "p2h_in_ready", p2h_in_ready, m_ready(mq_p.size(), md_p, pm));
      chk(hv ? "R6" : "R7", "h2p_out_data", h2p_out_data, hv ? mq_h[0] : ml_h);
      chk(pv ? "R6" : "R7", "p2h_out_data", p2h_out_data, pv ? mq_p[0] : ml_p);
      chk("R8", "par_nmi", par_nmi, mctl[3] && (hv || room));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #2;
  endtask
  task automatic idle();
    ctl_wr_en = 0; h2p_in_valid = 0; h2p_out_ready = 0; p2h_in_valid = 0; p2h_out_ready = 0;
  endtask
  task automatic ctl(logic [7:0] v);
    ctl_wr_en = 1; ctl_wr_data = v; tick(); idle();
  endtask
  task automatic hpush(logic [7:0] v);
    h2p_in_valid = 1; h2p_in_data = v; tick(); idle();
  endtask
  task automatic ppop();
    h2p_out_ready = 1; tick(); idle();
  endtask
  task automatic hpop();
    p2h_out_ready = 1; tick(); idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // set bits, then hard reset must clear them (R10)
    #(PERIOD * 2 + 2); rst_n = 1; tick();
    ctl(8'h98); tick();
    rst_n = 0; #(PERIOD * 2); rst_n = 1; tick();
    chk("R10", "pair/alert after reset", ctl_bits[4:3], 0);
    chk("R1", "reset ctl", ctl_bits, 0);
    chk("R1", "reset h2p ready/valid", {h2p_in_ready, h2p_out_valid}, 2'b10);
    chk("R1", "reset p2h ready/valid", {p2h_in_ready, p2h_out_valid}, 2'b01);
    chk("R1", "reset p2h byte", p2h_out_data, PRE);
    chk("R1", "reset nmi", par_nmi, 0);

    ctl(8'h88);
    chk("R8", "nmi held off by placeholder", par_nmi, 0);
    hpop();
    chk("R8", "nmi on p2h room", par_nmi, 1);

    hpush(8'h11);
    chk("R3", "single byte available", {h2p_out_valid, h2p_in_ready}, 2'b10);
    hpush(8'h22);
    chk("R7", "offer into full ignored", h2p_out_data, 8'h11);
    ppop();
    chk("R7", "empty shows last byte", {h2p_out_valid, h2p_out_data}, {1'b0, 8'h11});
    tick();
    chk("R7", "empty flags unchanged", {h2p_out_valid, h2p_in_ready}, 2'b01);

    ctl(8'h90);
    hpush(8'h33);
    chk("R4", "half pair not available", h2p_out_valid, 0);
    chk("R5", "ready until pair", h2p_in_ready, 1);
    hpush(8'h44);
    chk("R5", "ready low when pair full", {h2p_out_valid, h2p_in_ready}, 2'b10);
    chk("R6", "first of pair", h2p_out_data, 8'h33);
    ppop();
    chk("R4", "valid held mid pair", h2p_out_valid, 1);
    chk("R6", "second of pair", h2p_out_data, 8'h44);
    ppop();

    hpush(8'h55);
    ctl(8'hC0);
    chk("R9", "flush bit visible", ctl_bits[6], 1);
    hpush(8'h66);
    chk("R9", "flush cleared, others kept", ctl_bits, 7'h18);
    chk("R9", "h2p emptied", {h2p_in_ready, h2p_out_valid}, 2'b10);
    chk("R9", "p2h placeholder back", {p2h_in_ready, p2h_out_valid}, 2'b10);
    chk("R8", "pair mode nmi needs empty p2h", par_nmi, 0);

    // pseudo-random stretch checked against the reference
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4000; i++) begin
      h2p_in_valid  = $urandom % 2; h2p_in_data = $urandom;
      h2p_out_ready = ($urandom % 3) == 0;
      p2h_in_valid  = $urandom % 2; p2h_in_data = $urandom;
      p2h_out_ready = ($urandom % 3) == 0;
      ctl_wr_en = ($urandom % 25) == 0;
      ctl_wr_data = {1'($urandom), 7'($urandom) & ((($urandom % 4) == 0) ? 7'h7f : 7'h3f)};
      tick();
    end
    idle(); tick(); tick();
    finish_run();
  end
endmodule